// File: doc/BRIEF.md
# PHY-Side Link Port Sequencer

This block sits on the physical-layer chip and owns its half of the parallel bus to the link-layer chip. That bus has a 2-bit control field and an 8-bit data field, and both chips drive it at different times. While the PHY holds the bus, the block puts idle, status, receive and grant codes on the control field. It wraps each received packet in a data prefix and a speed byte. It sends payload on as many low data lines as the line speed needs.

When the PHY core asks for a grant, the block drives the grant code for one cycle and releases the bus for a turnaround cycle. It then watches what the link sends back. Transmit data is passed to the core. The block detects the two-cycle handback at the end of the packet. A hold code in that handback means another packet follows, so the link is granted again at once. When the link powers up, the block first runs a fixed start-up sequence. It drives everything low for a set number of cycles, and with DC coupling it adds one receive-prefix cycle after that.

Top module: `phy_link_port`

## Requirements
- R1: While reset is asserted, and until the link-power input is seen high, `bus_oe` is 0.
- R2: After `link_on` is seen high, the block drives `ctl_o`=00 and `d_o`=00h with `bus_oe`=1 for exactly 7 cycles. Any `rx_start`, `grant_req` or `st_req` during those cycles is ignored.
- R3: With `dc_mode`=1, the cycle after the 7 low cycles drives `ctl_o`=10 with `d_o`=FFh, and idle (00/00h) follows. With `dc_mode`=0, idle follows the low cycles directly.
- R4: An accepted `rx_start` gives one cycle of `ctl_o`=10 with `d_o`=FFh, then one cycle of `ctl_o`=10 with a speed byte. The speed byte is 00h when `rx_speed`=0 (100 Mbit/s), 40h when `rx_speed`=1 (200 Mbit/s), and 50h when `rx_speed` is 2 or 3 (400 Mbit/s). The speed is latched when `rx_start` is accepted.
- R5: In the payload cycles `ctl_o`=10. `d_o` carries `rx_data` masked to bits [1:0] at 100 Mbit/s, bits [3:0] at 200 Mbit/s and bits [7:0] at 400 Mbit/s. All unused lines are 0.
- R6: `rx_end` in a payload cycle marks that cycle's byte as the last one, and the next cycle is idle with `rx_err`=0. `rx_abort` in any receive cycle also makes the next cycle idle, and `rx_err`=1 for that one cycle.
- R7: An accepted `st_req` drives `ctl_o`=01 with the `st_data` latched at acceptance for one cycle, then idle.
- R8: An accepted `grant_req` drives `ctl_o`=11 with `d_o`=00h for one cycle. `bus_oe` then stays 0 through the turnaround cycle and while the link owns the bus.
- R9: While the link owns the bus, `tx_valid`=1 and `tx_data`=`d_i` in exactly the cycles where `ctl_i`=10 (transmit). Otherwise `tx_data`=0. A leading `ctl_i`=01 (hold) before any transmit keeps the link waiting.
- R10: After transmit data, `ctl_i`=00 followed by one more cycle gives `tx_done`=1 with `bus_oe`=0 in that cycle. The cycle after that, the block drives idle with `bus_oe`=1.
- R11: After transmit data, `ctl_i`=01 as the end code gives `tx_concat`=1 together with `tx_done`. The cycle after that is a new grant (`ctl_o`=11, `bus_oe`=1).
- R12: When requests arrive together in idle, `rx_start` wins over `grant_req`, and `grant_req` wins over `st_req`.
- R13: `link_on` going low in any state makes `bus_oe` 0 from the next cycle. Bringing it high again repeats the start-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_on | input | 1 | Link power status |
| dc_mode | input | 1 | 1 = DC-coupled bus, adds start-up prefix cycle |
| rx_start | input | 1 | Core request to forward a received packet |
| rx_speed | input | 2 | Received packet speed, 0=100, 1=200, 2/3=400 Mbit/s |
| rx_data | input | 8 | Payload bits for the current cycle |
| rx_end | input | 1 | Current payload cycle is the last |
| rx_abort | input | 1 | Abandon the packet being forwarded |
| grant_req | input | 1 | Core request to grant the bus to the link |
| st_req | input | 1 | Core request to send one status cycle |
| st_data | input | 8 | Status byte |
| ctl_i | input | 2 | Control field as driven by the link |
| d_i | input | 8 | Data field as driven by the link |
| ctl_o | output | 2 | Control field driven by the PHY |
| d_o | output | 8 | Data field driven by the PHY |
| bus_oe | output | 1 | 1 = PHY drives control and data fields |
| tx_valid | output | 1 | Link transmit byte present |
| tx_data | output | 8 | Link transmit byte |
| tx_done | output | 1 | Link handback completed this cycle |
| tx_concat | output | 1 | Handback ended with hold, regrant follows |
| rx_err | output | 1 | Previous cycle aborted a received packet |

## Verification
The receive path is swept over all four speed codes and over packet lengths of one to three bytes. The byte patterns have set bits in every lane, so a wrong mask or a speed code sent to the wrong lanes shows up. Start-up is run in both coupling modes while requests are held during the low cycles. This separates the extra prefix cycle from the block wrongly accepting a held request. Link transmissions end with an idle handback and with a hold handback, and some start with hold-waiting cycles. These runs tell apart a wait, a normal end and a concatenated end. Aborts in the prefix and payload cycles, simultaneous requests, and dropping link power in mid-packet cover the remaining exits.

// File: rtl/plp_pkg.sv
// Shared codes and state type for the PHY-side link port.
// Assumes an 8-bit data field and a 2-bit control field.
package plp_pkg;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 2;

    // codes the PHY drives
    localparam logic [CTL_W-1:0] C_IDLE    = 2'b00;
    localparam logic [CTL_W-1:0] C_STATUS  = 2'b01;
    localparam logic [CTL_W-1:0] C_RECEIVE = 2'b10;
    localparam logic [CTL_W-1:0] C_GRANT   = 2'b11;

    // codes the link drives
    localparam logic [CTL_W-1:0] L_IDLE = 2'b00;
    localparam logic [CTL_W-1:0] L_HOLD = 2'b01;
    localparam logic [CTL_W-1:0] L_XMIT = 2'b10;

    localparam logic [1:0] SPD_100 = 2'd0;
    localparam logic [1:0] SPD_200 = 2'd1;

    typedef enum logic [3:0] {
        S_OFF, S_WAKE, S_SYNC, S_IDLE,
        S_RXPRE, S_RXSPD, S_RXDAT, S_STAT,
        S_GRANT, S_TURN, S_LINK, S_END
    } state_t;
endpackage

// File: rtl/plp_startup.sv
// Start-up low-phase counter: done marks the last of LOW_CYC cycles.
// Assumes run stays high for the whole phase and drops afterwards.
module plp_startup #(
    parameter int LOW_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LOW_CYC + 1);

    logic [CW-1:0] cnt_q;

    // count cycles spent in the low phase, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    // flag the final low cycle
    always_comb done = run && (cnt_q == CW'(LOW_CYC - 1));
endmodule

// File: rtl/plp_rx_format.sv
// Builds the speed byte and the lane-masked payload for received packets.
// Speeds 2 and 3 both mean the widest lane set.
module plp_rx_format
    import plp_pkg::*;
#(
    parameter int LANES_S100 = 2,
    parameter int LANES_S200 = 4
) (
    input  logic [1:0]        spd,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] spd_byte,
    output logic [DATA_W-1:0] payload
);
    logic [DATA_W-1:0] mask;
    int unsigned       lanes;

    // pick the prefix-coded speed byte
    always_comb begin
        case (spd)
            SPD_100: spd_byte = 8'h00;
            SPD_200: spd_byte = 8'h40;
            default: spd_byte = 8'h50;
        endcase
    end

    // number of active low-order lanes for this speed
    always_comb begin
        case (spd)
            SPD_100: lanes = LANES_S100;
            SPD_200: lanes = LANES_S200;
            default: lanes = DATA_W;
        endcase
    end

    // one mask bit per lane
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign mask[g] = (g < lanes);
    end

    // drive unused lanes low
    always_comb payload = raw & mask;
endmodule

// File: rtl/plp_handback.sv
// Watches the link-driven control field while the link owns the bus.
// Detects transmit cycles, the end code, and whether it was a hold.
module plp_handback
    import plp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_link,
    input  logic [CTL_W-1:0] ctl_i,
    output logic             xmit,
    output logic             end_now,
    output logic             hold_q
);
    logic seen_q;

    // transmit cycle and end-of-ownership detection
    always_comb begin
        xmit    = in_link && (ctl_i == L_XMIT);
        end_now = in_link && (seen_q ? (ctl_i != L_XMIT) : (ctl_i == L_IDLE));
    end

    // remember that data has started in this ownership
    always_ff @(posedge clk) begin
        if (!rst_n || !in_link) seen_q <= 1'b0;
        else if (xmit)          seen_q <= 1'b1;
    end

    // capture whether the end code asked for concatenation
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (end_now) hold_q <= seen_q && (ctl_i == L_HOLD);
    end
endmodule

// File: rtl/phy_link_port.sv
// PHY-side controller of the parallel PHY-to-link bus.
// Owns the bus except between a grant and the link's handback.
// Assumes core requests are held until seen in the idle state.
module phy_link_port
    import plp_pkg::*;
#(
    parameter int LOW_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_on,
    input  logic              dc_mode,
    input  logic              rx_start,
    input  logic [1:0]        rx_speed,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_abort,
    input  logic              grant_req,
    input  logic              st_req,
    input  logic [DATA_W-1:0] st_data,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] d_o,
    output logic              bus_oe,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_done,
    output logic              tx_concat,
    output logic              rx_err
);
    state_t            state_q, state_d;
    logic [1:0]        spd_q;
    logic [DATA_W-1:0] st_q;
    logic              err_q;
    logic              wake_done, xmit, end_now, hold_q, in_rx;
    logic [DATA_W-1:0] spd_byte, payload;

    plp_startup #(.LOW_CYC(LOW_CYC)) i_startup (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_WAKE), .done(wake_done)
    );

    plp_rx_format i_rx_format (
        .spd(spd_q), .raw(rx_data), .spd_byte(spd_byte), .payload(payload)
    );

    plp_handback i_handback (
        .clk(clk), .rst_n(rst_n), .in_link(state_q == S_LINK), .ctl_i(ctl_i),
        .xmit(xmit), .end_now(end_now), .hold_q(hold_q)
    );

    always_comb in_rx = (state_q == S_RXPRE) || (state_q == S_RXSPD) || (state_q == S_RXDAT);

    // next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_OFF:   if (link_on) state_d = S_WAKE;
            S_WAKE:  if (wake_done) state_d = dc_mode ? S_SYNC : S_IDLE;
            S_SYNC:  state_d = S_IDLE;
            S_IDLE: begin
                if (rx_start)       state_d = S_RXPRE;
                else if (grant_req) state_d = S_GRANT;
                else if (st_req)    state_d = S_STAT;
            end
            S_RXPRE: state_d = rx_abort ? S_IDLE : S_RXSPD;
            S_RXSPD: state_d = rx_abort ? S_IDLE : S_RXDAT;
            S_RXDAT: if (rx_abort || rx_end) state_d = S_IDLE;
            S_STAT:  state_d = S_IDLE;
            S_GRANT: state_d = S_TURN;
            S_TURN:  state_d = S_LINK;
            S_LINK:  if (end_now) state_d = S_END;
            S_END:   state_d = hold_q ? S_GRANT : S_IDLE;
            default: state_d = S_OFF;
        endcase
        if (!link_on) state_d = S_OFF;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // latch speed and status byte when their request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q <= SPD_100;
            st_q  <= '0;
        end else if (state_q == S_IDLE) begin
            if (rx_start)                    spd_q <= rx_speed;
            if (!rx_start && !grant_req && st_req) st_q <= st_data;
        end
    end

    // one-cycle abort flag
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= in_rx && rx_abort && link_on;
    end

    // bus drive per state
    always_comb begin
        bus_oe = 1'b1;
        ctl_o  = C_IDLE;
        d_o    = '0;
        case (state_q)
            S_OFF, S_TURN, S_LINK, S_END: bus_oe = 1'b0;
            S_SYNC, S_RXPRE: begin
                ctl_o = C_RECEIVE;
                d_o   = '1;
            end
            S_RXSPD: begin
                ctl_o = C_RECEIVE;
                d_o   = spd_byte;
            end
            S_RXDAT: begin
                ctl_o = C_RECEIVE;
                d_o   = payload;
            end
            S_STAT: begin
                ctl_o = C_STATUS;
                d_o   = st_q;
            end
            S_GRANT: ctl_o = C_GRANT;
            default: ;
        endcase
    end

    // core-side outputs
    always_comb begin
        tx_valid  = xmit;
        tx_data   = xmit ? d_i : '0;
        tx_done   = (state_q == S_END);
        tx_concat = (state_q == S_END) && hold_q;
        rx_err    = err_q;
    end
endmodule

// File: rtl/phy_link_port_chk.sv
// Temporal checks on the PHY-side link port, bound to every instance.
module phy_link_port_chk
    import plp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              link_on,
    input logic              rx_abort,
    input state_t            state_q,
    input logic [1:0]        spd_q,
    input logic [CTL_W-1:0]  ctl_o,
    input logic [DATA_W-1:0] d_o,
    input logic              bus_oe,
    input logic              tx_done,
    input logic              tx_concat,
    input logic              rx_err
);
    AST_POWER_LOSS_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |=> !bus_oe); // R13
    AST_GRANT_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && ctl_o == C_GRANT && link_on) |=> !bus_oe); // R8
    AST_PREFIX_THEN_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RXPRE && !rx_abort && link_on) |=> (ctl_o == C_RECEIVE && d_o[7] == 1'b0)); // R4
    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RXPRE || state_q == S_RXSPD || state_q == S_RXDAT) && rx_abort && link_on)
        |=> (rx_err && bus_oe && ctl_o == C_IDLE)); // R6
    AST_SLOW_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RXDAT && spd_q == SPD_100) |-> (d_o[7:2] == 6'd0)); // R5
    AST_DONE_WHILE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !bus_oe); // R10
    AST_CONCAT_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_concat && link_on) |=> (bus_oe && ctl_o == C_GRANT)); // R11
endmodule

bind phy_link_port phy_link_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .link_on(link_on), .rx_abort(rx_abort),
    .state_q(state_q), .spd_q(spd_q), .ctl_o(ctl_o), .d_o(d_o),
    .bus_oe(bus_oe), .tx_done(tx_done), .tx_concat(tx_concat), .rx_err(rx_err)
);

// File: tb/test_phy_link_port.sv
module test_phy_link_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_on = 1'b0, dc_mode = 1'b0;
    logic       rx_start = 1'b0, rx_end = 1'b0, rx_abort = 1'b0;
    logic [1:0] rx_speed = 2'd0;
    logic [7:0] rx_data = 8'h00;
    logic       grant_req = 1'b0, st_req = 1'b0;
    logic [7:0] st_data = 8'h00;
    logic [1:0] ctl_i = 2'b00;
    logic [7:0] d_i = 8'h00;
    logic [1:0] ctl_o;
    logic [7:0] d_o, tx_data;
    logic       bus_oe, tx_valid, tx_done, tx_concat, rx_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    phy_link_port i_phy_link_port (
        .clk(clk), .rst_n(rst_n), .link_on(link_on), .dc_mode(dc_mode),
        .rx_start(rx_start), .rx_speed(rx_speed), .rx_data(rx_data),
        .rx_end(rx_end), .rx_abort(rx_abort), .grant_req(grant_req),
        .st_req(st_req), .st_data(st_data), .ctl_i(ctl_i), .d_i(d_i),
        .ctl_o(ctl_o), .d_o(d_o), .bus_oe(bus_oe), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_done(tx_done), .tx_concat(tx_concat), .rx_err(rx_err)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // check the PHY-driven bus: oe, control, data
    task automatic chk_bus(input string req, input logic oe, input logic [1:0] c, input logic [7:0] d);
        #1;
        chk(req, 32'({bus_oe, ctl_o, d_o}), 32'({oe, c, d}));
    endtask

    function automatic logic [7:0] spd_code(input int s);
        return (s == 0) ? 8'h00 : (s == 1) ? 8'h40 : 8'h50;
    endfunction

    function automatic logic [7:0] lane_mask(input int s);
        int lanes = (s == 0) ? 2 : (s == 1) ? 4 : 8;
        return 8'((1 << lanes) - 1);
    endfunction

    task automatic wake_up(input logic dc);
        dc_mode = dc;
        link_on = 1'b1;
        repeat (8 + (dc ? 1 : 0)) tick();
    endtask

    // run one link ownership: waits, bytes, then end code
    task automatic link_turn(input int waits, input int nbytes, input logic hold);
        chk_bus("R8 grant", 1'b1, 2'b11, 8'h00);
        grant_req = 1'b0;
        tick();
        chk_bus("R8 turnaround", 1'b0, 2'b00, 8'h00);
        tick();
        for (int w = 0; w < waits; w++) begin
            ctl_i = 2'b01;
            #1;
            chk("R9 wait no data", 32'({bus_oe, tx_valid, tx_data}), 32'd0);
            tick();
        end
        for (int b = 0; b < nbytes; b++) begin
            ctl_i = 2'b10;
            d_i = 8'h3C + 8'(b * 37);
            #1;
            chk("R9 tx byte", 32'({bus_oe, tx_valid, tx_data}), 32'({1'b0, 1'b1, 8'h3C + 8'(b * 37)}));
            tick();
        end
        ctl_i = hold ? 2'b01 : 2'b00;
        d_i = 8'h00;
        tick();
        ctl_i = 2'b00;
        #1;
        chk(hold ? "R11 concat end" : "R10 plain end", 32'({bus_oe, tx_done, tx_concat}), 32'({1'b0, 1'b1, hold}));
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        link_on = 1'b1;
        repeat (3) tick();
        chk_bus("R1 reset floats", 1'b0, 2'b00, 8'h00);
        link_on = 1'b0;
        rst_n = 1'b1;
        repeat (2) tick();
        chk_bus("R1 off floats", 1'b0, 2'b00, 8'h00);

        // start-up in both coupling modes, requests held throughout
        for (int dc = 0; dc < 2; dc++) begin
            link_on = 1'b0;
            tick();
            chk_bus("R13 link off", 1'b0, 2'b00, 8'h00);
            dc_mode = dc[0];
            link_on = 1'b1;
            rx_start = 1'b1;
            grant_req = 1'b1;
            st_req = 1'b1;
            tick();
            for (int i = 0; i < 7; i++) begin
                chk_bus("R2 low phase", 1'b1, 2'b00, 8'h00);
                if (i == 6) begin
                    rx_start = 1'b0;
                    grant_req = 1'b0;
                    st_req = 1'b0;
                end
                tick();
            end
            if (dc == 1) chk_bus("R3 dc prefix", 1'b1, 2'b10, 8'hFF);
            else         chk_bus("R3 ac idle", 1'b1, 2'b00, 8'h00);
            tick();
            chk_bus("R3 idle after", 1'b1, 2'b00, 8'h00);
        end

        // receive sweep: every speed, lengths 1..3
        for (int s = 0; s < 4; s++) begin
            for (int len = 1; len <= 3; len++) begin
                rx_start = 1'b1;
                rx_speed = 2'(s);
                tick();
                rx_start = 1'b0;
                rx_speed = 2'(3 - s);
                chk_bus("R4 prefix", 1'b1, 2'b10, 8'hFF);
                tick();
                chk_bus("R4 speed byte", 1'b1, 2'b10, spd_code(s));
                tick();
                for (int b = 0; b < len; b++) begin
                    rx_data = 8'hA7 ^ 8'(b * 91 + s * 17);
                    rx_end = (b == len - 1);
                    chk_bus("R5 payload", 1'b1, 2'b10, (8'hA7 ^ 8'(b * 91 + s * 17)) & lane_mask(s));
                    tick();
                end
                rx_end = 1'b0;
                #1;
                chk("R6 end idle", 32'({bus_oe, ctl_o, rx_err}), 32'({1'b1, 2'b00, 1'b0}));
            end
        end

        // abort in payload and in prefix
        for (int where = 0; where < 2; where++) begin
            rx_start = 1'b1;
            rx_speed = 2'd2;
            tick();
            rx_start = 1'b0;
            if (where == 1) repeat (2) tick();
            rx_abort = 1'b1;
            tick();
            rx_abort = 1'b0;
            #1;
            chk("R6 abort", 32'({bus_oe, ctl_o, rx_err}), 32'({1'b1, 2'b00, 1'b1}));
            tick();
            chk("R6 err pulse", 32'(rx_err), 32'd0);
        end

        // status cycle
        st_req = 1'b1;
        st_data = 8'h96;
        tick();
        st_req = 1'b0;
        st_data = 8'h00;
        chk_bus("R7 status", 1'b1, 2'b01, 8'h96);
        tick();
        chk_bus("R7 back idle", 1'b1, 2'b00, 8'h00);

        // priority
        rx_start = 1'b1;
        grant_req = 1'b1;
        st_req = 1'b1;
        tick();
        rx_start = 1'b0;
        chk_bus("R12 receive first", 1'b1, 2'b10, 8'hFF);
        rx_abort = 1'b1;
        tick();
        rx_abort = 1'b0;
        tick();
        st_req = 1'b0;
        link_turn(0, 1, 1'b0);
        chk_bus("R12 grant before status", 1'b1, 2'b00, 8'h00);

        // link ownership: plain, waited, concatenated
        grant_req = 1'b1;
        tick();
        link_turn(2, 3, 1'b0);
        chk_bus("R10 phy retakes", 1'b1, 2'b00, 8'h00);
        grant_req = 1'b1;
        tick();
        link_turn(0, 2, 1'b1);
        link_turn(1, 1, 1'b0);
        chk_bus("R11 chain closes", 1'b1, 2'b00, 8'h00);

        // power loss in mid-packet, then restart
        rx_start = 1'b1;
        tick();
        rx_start = 1'b0;
        repeat (2) tick();
        link_on = 1'b0;
        tick();
        chk_bus("R13 drop mid packet", 1'b0, 2'b00, 8'h00);
        wake_up(1'b0);
        chk_bus("R13 restarted idle", 1'b1, 2'b00, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule